// File: doc/BRIEF.md
# Exponentiation-Based GF(2^m) Inverter

This block returns the multiplicative inverse of a nonzero element of the binary extension field GF(2^m). The element is held in polynomial basis, with bit i as the coefficient of x^i. The field polynomial is fixed when the block is elaborated. The inverter uses the identity b^(2^m - 1) = 1, so the inverse of b is b^(2^m - 2). Because 2^m - 2 = 2 + 4 + ... + 2^(m-1), the block squares a running power m-1 times and multiplies each new square into an accumulator. The first square loads the accumulator directly, so the schedule needs m-2 general multiplications.

Each squaring spreads the input bits apart, moving bit i to position 2i and filling the odd positions with zeros. A fixed XOR network then reduces the spread word. The multiplier is fully combinational and gives one reduced product per clock. The result is ready m-1 cycles after an operand is accepted. A zero operand has no inverse, so it completes with an error flag set and a zero result.

Operands enter on a valid/ready pair. `in_ready` is high only while the block is idle. Results leave on a valid/ready pair. `out_valid` and the result stay asserted and unchanged until the consumer raises `out_ready`. The block returns to idle in the cycle after that handshake.

Top module: `gf_fermat_inv`

## Requirements
- R1: For every nonzero operand a, the field product of a and the returned result, reduced by the field polynomial (default x^8+x^4+x^3+x+1, 0x11B, with m = 8), equals 1.
- R2: `out_valid` rises exactly m-1 clock edges after the edge on which `in_valid` and `in_ready` are both high.
- R3: `in_ready` is high exactly when no operation is running and no result is held. An `in_valid` presented while `in_ready` is low has no effect on the pending result.
- R4: A zero operand completes with `out_err` = 1 and `out_result` = 0.
- R5: A nonzero operand completes with `out_err` = 0.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result` and `out_err` hold their values.
- R7: The operand 0x01 returns 0x01.
- R8: With the default parameters, the operand 0x53 returns 0xCA.
- R9: During reset, `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Block idle and able to take an operand |
| in_data | input | P_WIDTH | Operand in polynomial basis |
| out_valid | output | 1 | Result held for the consumer |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | P_WIDTH | Inverse, or zero on error |
| out_err | output | 1 | Operand was zero |

## Verification
Some properties are checked on every cycle by the assertions:
- A held result stays stable under back-pressure.
- `in_ready` falls after each acceptance.
- `out_valid` rises exactly m-1 edges after acceptance.
- The error flag and a zero result go together.
- Multiplying by one passes the other operand through.

Field correctness needs the bench's scenarios. The bench sweeps every nonzero operand and checks each result against an independent shift-and-XOR product. It also runs the fixed cases for one and 0x53, and the zero case. Further scenarios stall the consumer and offer operands while the block is busy.

// File: rtl/gf_inv_pkg.sv
package gf_inv_pkg;
  localparam int DEF_WIDTH = 8;
  localparam logic [DEF_WIDTH:0] DEF_POLY = 9'h11B;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } inv_state_e;
endpackage

// File: rtl/gf_reduce.sv
module gf_reduce #(
  parameter int W = 8,
  parameter logic [W:0] POLY = 9'h11B
) (
  input  logic [2*W-2:0] wide_i,
  output logic [W-1:0]   narrow_o
);
  localparam int WW = 2 * W - 1;

  logic [WW-1:0] work;

  // Fold each high term back, from the top degree down.
  always_comb begin
    work = wide_i;
    for (int k = WW - 1; k >= W; k--) begin
      if (work[k]) begin
        work[k-W +: W+1] = work[k-W +: W+1] ^ POLY;
      end
    end
    narrow_o = work[W-1:0];
  end
endmodule

// File: rtl/gf_sqr.sv
module gf_sqr #(
  parameter int W = 8,
  parameter logic [W:0] POLY = 9'h11B
) (
  input  logic [W-1:0] a_i,
  output logic [W-1:0] sq_o
);
  localparam int WW = 2 * W - 1;

  logic [WW-1:0] spread;

  // Squaring over GF(2): cross terms cancel, so the bits only spread apart.
  for (genvar i = 0; i < W; i++) begin : g_even
    assign spread[2*i] = a_i[i];
  end
  for (genvar i = 0; i < W - 1; i++) begin : g_odd
    assign spread[2*i+1] = 1'b0;
  end

  gf_reduce #(.W(W), .POLY(POLY)) u_red (
    .wide_i   (spread),
    .narrow_o (sq_o)
  );
endmodule

// File: rtl/gf_mul.sv
module gf_mul #(
  parameter int W = 8,
  parameter logic [W:0] POLY = 9'h11B
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic [W-1:0] p_o
);
  localparam int WW = 2 * W - 1;

  logic [WW-1:0] pp [W];
  logic [WW-1:0] raw;

  for (genvar j = 0; j < W; j++) begin : g_pp
    assign pp[j] = b_i[j] ? (WW'(a_i) << j) : '0;
  end

  always_comb begin
    raw = '0;
    for (int j = 0; j < W; j++) begin
      raw = raw ^ pp[j];
    end
  end

  gf_reduce #(.W(W), .POLY(POLY)) u_red (
    .wide_i   (raw),
    .narrow_o (p_o)
  );

  // R1 support: the multiplicative identity passes the other operand through.
  always_comb begin
    if (b_i == W'(1)) begin
      a_r1_mul_identity: assert (p_o == a_i);
    end
  end
endmodule

// File: rtl/gf_inv_ctrl.sv
module gf_inv_ctrl
  import gf_inv_pkg::*;
#(
  parameter int W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic out_ready,
  output logic in_ready,
  output logic out_valid,
  output logic load_o,
  output logic step_o
);
  localparam int SW = $clog2(W) + 1;
  localparam logic [SW-1:0] LAST = SW'(W - 1);

  inv_state_e state_q;
  logic [SW-1:0] sq_cnt_q;

  assign in_ready  = (state_q == ST_IDLE);
  assign out_valid = (state_q == ST_HOLD);
  assign load_o    = in_valid && in_ready;
  assign step_o    = (state_q == ST_RUN);

  // sq_cnt_q is the number of squarings done so far.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      sq_cnt_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (load_o) begin
          sq_cnt_q <= SW'(1);
          state_q  <= (LAST == SW'(1)) ? ST_HOLD : ST_RUN;
        end
        ST_RUN: begin
          sq_cnt_q <= sq_cnt_q + SW'(1);
          if (sq_cnt_q + SW'(1) == LAST) state_q <= ST_HOLD;
        end
        ST_HOLD: if (out_ready) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // Independent cycle counter for the latency check.
  int unsigned since_q;
  always_ff @(posedge clk) begin
    if (!rst_n) since_q <= 0;
    else if (load_o) since_q <= 1;
    else if (step_o) since_q <= since_q + 1;
  end

  a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> since_q == unsigned'(W - 1));

  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  a_r6_valid_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
endmodule

// File: rtl/gf_fermat_inv.sv
module gf_fermat_inv
  import gf_inv_pkg::*;
#(
  parameter int P_WIDTH = DEF_WIDTH,
  parameter logic [P_WIDTH:0] P_POLY = DEF_POLY
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [P_WIDTH-1:0] in_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [P_WIDTH-1:0] out_result,
  output logic               out_err
);
  logic load, step;
  logic [P_WIDTH-1:0] pow_q, acc_q, sq_in, sq_out, prod;
  logic err_q;

  gf_inv_ctrl #(.W(P_WIDTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .load_o    (load),
    .step_o    (step)
  );

  assign sq_in = load ? in_data : pow_q;

  gf_sqr #(.W(P_WIDTH), .POLY(P_POLY)) u_sqr (
    .a_i  (sq_in),
    .sq_o (sq_out)
  );

  gf_mul #(.W(P_WIDTH), .POLY(P_POLY)) u_mul (
    .a_i (acc_q),
    .b_i (sq_out),
    .p_o (prod)
  );

  // The first square seeds the accumulator; each later square is multiplied in.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pow_q <= '0;
      acc_q <= '0;
      err_q <= 1'b0;
    end else if (load) begin
      pow_q <= sq_out;
      acc_q <= sq_out;
      err_q <= (in_data == '0);
    end else if (step) begin
      pow_q <= sq_out;
      acc_q <= prod;
    end
  end

  assign out_result = acc_q;
  assign out_err    = err_q;

  a_r6_result_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> ($stable(out_result) && $stable(out_err)));

  a_r4_zero_result: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_err) |-> (out_result == '0));

  a_r5_nonzero_inverse: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_err) |-> (out_result != '0));
endmodule

// File: tb/gf_fermat_inv_tb_top.sv
module gf_fermat_inv_tb_top;
  localparam int W = 8;
  localparam logic [W:0] POLY = 9'h11B;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic out_ready = 1'b0;
  logic [W-1:0] in_data = '0;
  logic in_ready, out_valid, out_err;
  logic [W-1:0] out_result;

  always #5 clk = ~clk;

  gf_fermat_inv #(.P_WIDTH(W), .P_POLY(POLY)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_err(out_err)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string tag_res = "R1";

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r = '0;
    logic [W-1:0] x = a;
    logic top;
    for (int i = 0; i < W; i++) begin
      if (b[i]) r = r ^ x;
      top = x[W-1];
      x = x << 1;
      if (top) x = x ^ POLY[W-1:0];
    end
    return r;
  endfunction

  function automatic logic [W-1:0] ref_inv(input logic [W-1:0] a);
    if (a == '0) return '0;
    for (int y = 1; y < (1 << W); y++) begin
      if (ref_mul(a, W'(y)) == W'(1)) return W'(y);
    end
    return '0;
  endfunction

  // Behavioural reference: idle -> busy (m-1 edges) -> hold.
  logic m_busy, m_hold, m_err;
  int m_cnt;
  logic [W-1:0] m_data, m_res;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy <= 1'b0; m_hold <= 1'b0; m_cnt <= 0;
      m_data <= '0; m_res <= '0; m_err <= 1'b0;
    end else if (!m_busy && !m_hold) begin
      if (in_valid) begin
        m_busy <= 1'b1; m_cnt <= 1; m_data <= in_data;
      end
    end else if (m_busy) begin
      if (m_cnt == W - 2) begin
        m_busy <= 1'b0; m_hold <= 1'b1;
        m_res <= ref_inv(m_data); m_err <= (m_data == '0);
      end else begin
        m_cnt <= m_cnt + 1;
      end
    end else if (out_ready) begin
      m_hold <= 1'b0;
    end
  end

  // Per-cycle comparison, away from the active edge.
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3", 32'(in_ready), 32'(!m_busy && !m_hold));
      chk("R2", 32'(out_valid), 32'(m_hold));
      if (m_hold && out_valid) begin
        chk(tag_res, 32'(out_result), 32'(m_res));
        chk(m_err ? "R4" : "R5", 32'(out_err), 32'(m_err));
        if (m_data != '0) chk("R1", 32'(ref_mul(m_data, out_result)), 32'(1));
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      finish_run();
    end
  end

  task automatic run_one(input logic [W-1:0] x, input string tag, input int stall, input bit junk);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    tag_res = tag;
    in_valid = 1'b1; in_data = x;
    @(negedge clk);
    in_valid = junk; in_data = ~x;
    while (!out_valid) @(negedge clk);
    for (int s = 0; s < stall; s++) @(negedge clk);
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    tag_res = "R1";
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R9", 32'(in_ready), 32'(1));
    chk("R9", 32'(out_valid), 32'(0));
    rst_n = 1'b1;

    run_one(8'h53, "R8", 0, 1'b0);
    run_one(8'h01, "R7", 0, 1'b0);
    run_one(8'h00, "R4", 0, 1'b0);
    // Back-pressure with operands offered while busy and while holding.
    run_one(8'hA7, "R6", 5, 1'b1);
    run_one(8'h80, "R3", 3, 1'b1);
    for (int v = 1; v < (1 << W); v++) begin
      run_one(W'(v), "R1", v % 3, 1'b0);
    end
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule